// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit core. Eight request flags come in from two external interrupt pins, three timers and a serial port. They are folded into six vector groups. The serial receive and transmit flags share one group, and the two timer-2 events share another. Each group has its own enable bit and its own priority bit. One global enable gates all of them. At the end of an instruction the controller picks the winning group, raises a one-cycle acknowledge and presents the fixed handler address for that group.

Two in-service bits, one for each level, record which handlers are running. A high-level request can interrupt a running low-level handler. A running handler blocks every request of its own level or below. The core reports three things: every instruction boundary, any instruction that is a return from interrupt, and any access to the enable or priority registers. The boundary that ends either of those two kinds of instruction is never used for an entry, so at least one more instruction runs first.

The four single-source groups have their flags cleared by the controller. It sends them a one-cycle clear pulse with the acknowledge. The two shared groups are left to software to clear.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `take_o`, `take_lvl_o`, `vec_o` and `flag_ack_o` are all zero, and both in-service levels are idle.
- R2: A group is pending only while its flag (or either flag of a shared group), its bit in `grp_en` and `glob_en` are all 1. A request that is masked locally or globally is never taken.
- R3: Requests are registered once before arbitration. A flag that first rises in the same cycle as `insn_done` is not taken at that boundary, but it can be taken at the next one.
- R4: An entry is made only in a cycle where `insn_done` is 1. Pending requests with no boundary produce no acknowledge.
- R5: Groups are numbered 0 to 5: ext0, tmr0, ext1, tmr1, serial (rx|tx), timer 2 (ovf|ext). Bit i of `grp_en`, `grp_hi` and `flag_ack_o` refers to group i. Within one level the lowest-numbered pending group wins. Its vector is 0x0003 + 8*i, so 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R6: A pending group whose `grp_hi` bit is 1 is served before any pending low-level group, whatever their numbering.
- R7: A high-level request is taken while only a low-level handler runs. A low-level request is taken only when no handler runs. A high-level request is not taken while a high-level handler runs.
- R8: A cycle with `ret_irq` high clears the high in-service bit if it is set, and otherwise clears the low one. A low handler that was preempted stays in service after the high handler returns.
- R9: A boundary is not used for an entry if `ret_irq` was high during it, or if `guard_insn` was high at any cycle since the previous boundary, that boundary included. The following boundary is used normally.
- R10: On an entry to group 0 to 3, exactly the matching bit of `flag_ack_o` pulses together with `take_o`. Entries to groups 4 and 5 pulse no `flag_ack_o` bit.
- R11: `take_o` is a one-cycle pulse in the cycle after the deciding boundary. `take_lvl_o` (1 = high) and `vec_o` are updated at the same edge, and `vec_o` holds its value until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_flag | input | 1 | External interrupt 0 request flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External interrupt 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| rx_flag | input | 1 | Serial receive-done flag |
| tx_flag | input | 1 | Serial transmit-done flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external event flag |
| grp_en | input | 6 | Per-group enable, bit i = group i |
| glob_en | input | 1 | Global enable |
| grp_hi | input | 6 | Per-group priority, 1 = high level |
| insn_done | input | 1 | Instruction boundary strobe |
| guard_insn | input | 1 | Enable/priority register access in the current instruction |
| ret_irq | input | 1 | Current instruction is a return from interrupt |
| take_o | output | 1 | Interrupt acknowledge pulse |
| take_lvl_o | output | 1 | Level of the entry, 1 = high |
| vec_o | output | 16 | Handler address of the last entry |
| flag_ack_o | output | 4 | Hardware clear pulse for groups 0 to 3 |

## Verification
If an in-service bit is left set or cleared wrongly, the error shows at the ports only at a later boundary. The symptom is either an acknowledge that should have come and does not, or a nesting violation. For that reason each preemption case is followed by returns and further boundaries until both levels are idle again. A wrong blocked-window flag either lets through an entry at the boundary of a return, or holds back the entry one boundary later. Both show within two boundaries. An arbitration or vector fault changes `vec_o` or `flag_ack_o` in the very acknowledge cycle, and every acknowledge is compared against the queued expectation.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NGRP   = 6;
  localparam int unsigned IDX_W  = $clog2(NGRP);
  localparam int unsigned NHWACK = 4;

  typedef logic [NGRP-1:0]  grp_vec_t;
  typedef logic [IDX_W-1:0] grp_idx_t;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/irqc_req_sync.sv
module irqc_req_sync
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  grp_vec_t grp_req,
  input  grp_vec_t grp_en,
  input  logic     glob_en,
  output grp_vec_t pend_q
);
  for (genvar g = 0; g < NGRP; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= grp_req[g] & grp_en[g] & glob_en;
    end
  end

`ifndef SYNTHESIS
  // R2
  masked_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (pend_q == '0));
`endif
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  grp_vec_t pend,
  input  grp_vec_t prio,
  input  logic     isr_hi,
  input  logic     isr_lo,
  output logic     sel_valid,
  output lvl_e     sel_lvl,
  output grp_idx_t sel_idx
);
  grp_vec_t hi_req, lo_req;

  function automatic grp_idx_t lowest_set(input grp_vec_t v);
    grp_idx_t r;
    r = '0;
    for (int i = NGRP - 1; i >= 0; i--) begin
      if (v[i]) r = grp_idx_t'(i);
    end
    return r;
  endfunction

  always_comb begin
    hi_req    = pend & prio;
    lo_req    = pend & ~prio;
    sel_valid = 1'b0;
    sel_lvl   = LVL_LO;
    sel_idx   = '0;
    if (!isr_hi && (|hi_req)) begin
      sel_valid = 1'b1;
      sel_lvl   = LVL_HI;
      sel_idx   = lowest_set(hi_req);
    end else if (!isr_hi && !isr_lo && (|lo_req)) begin
      sel_valid = 1'b1;
      sel_lvl   = LVL_LO;
      sel_idx   = lowest_set(lo_req);
    end
  end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic insn_done,
  input  logic guard_insn,
  input  logic ret_irq,
  input  logic take,
  input  lvl_e take_lvl,
  output logic isr_hi,
  output logic isr_lo,
  output logic allow
);
  logic blk_q;

  assign allow = !(blk_q || guard_insn || ret_irq);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
    end else if (insn_done) begin
      blk_q <= 1'b0;
    end else if (guard_insn || ret_irq) begin
      blk_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else if (take) begin
      if (take_lvl == LVL_HI) isr_hi <= 1'b1;
      else                    isr_lo <= 1'b1;
    end else if (ret_irq) begin
      if (isr_hi) isr_hi <= 1'b0;
      else        isr_lo <= 1'b0;
    end
  end

`ifndef SYNTHESIS
  // R8
  ret_hi_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_irq && isr_hi && isr_lo) |=> (!isr_hi && isr_lo));
  // R7
  hi_no_renest_chk: assert property (@(posedge clk) disable iff (rst)
    (take && take_lvl == LVL_HI) |-> !isr_hi);
  // R9
  ret_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
    ret_irq |-> !take);
`endif
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext0_flag,
  input  logic              tmr0_flag,
  input  logic              ext1_flag,
  input  logic              tmr1_flag,
  input  logic              rx_flag,
  input  logic              tx_flag,
  input  logic              tmr2_ovf_flag,
  input  logic              tmr2_ext_flag,
  input  logic [NGRP-1:0]   grp_en,
  input  logic              glob_en,
  input  logic [NGRP-1:0]   grp_hi,
  input  logic              insn_done,
  input  logic              guard_insn,
  input  logic              ret_irq,
  output logic              take_o,
  output logic              take_lvl_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [NHWACK-1:0] flag_ack_o
);
  grp_vec_t grp_req, pend;
  logic     sel_valid, isr_hi, isr_lo, allow, take;
  lvl_e     sel_lvl;
  grp_idx_t sel_idx;
  logic [NHWACK-1:0] ack_d;
  logic [ADDR_W-1:0] vec_d;

  assign grp_req = {tmr2_ovf_flag | tmr2_ext_flag, rx_flag | tx_flag,
                    tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};

  irqc_req_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .grp_req (grp_req),
    .grp_en  (grp_en),
    .glob_en (glob_en),
    .pend_q  (pend)
  );

  irqc_arbiter u_arb (
    .pend      (pend),
    .prio      (grp_hi),
    .isr_hi    (isr_hi),
    .isr_lo    (isr_lo),
    .sel_valid (sel_valid),
    .sel_lvl   (sel_lvl),
    .sel_idx   (sel_idx)
  );

  assign take = insn_done && allow && sel_valid;

  irqc_nest u_nest (
    .clk        (clk),
    .rst        (rst),
    .insn_done  (insn_done),
    .guard_insn (guard_insn),
    .ret_irq    (ret_irq),
    .take       (take),
    .take_lvl   (sel_lvl),
    .isr_hi     (isr_hi),
    .isr_lo     (isr_lo),
    .allow      (allow)
  );

  assign vec_d = ADDR_W'(VEC_BASE) + ADDR_W'(sel_idx) * ADDR_W'(VEC_STRIDE);

  for (genvar a = 0; a < NHWACK; a++) begin : g_ack
    assign ack_d[a] = take && (sel_idx == IDX_W'(a));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o     <= 1'b0;
      take_lvl_o <= 1'b0;
      vec_o      <= '0;
      flag_ack_o <= '0;
    end else begin
      take_o     <= take;
      flag_ack_o <= ack_d;
      if (take) begin
        take_lvl_o <= (sel_lvl == LVL_HI);
        vec_o      <= vec_d;
      end
    end
  end

`ifndef SYNTHESIS
  // R4
  take_on_bnd_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(insn_done));
  // R9
  take_not_guarded_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!$past(guard_insn) && !$past(ret_irq)));
  // R7
  lo_idle_only_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && !take_lvl_o) |-> (!$past(isr_hi) && !$past(isr_lo)));
  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_ack_o));
  // R10
  ack_with_take_chk: assert property (@(posedge clk) disable iff (rst)
    (|flag_ack_o) |-> take_o);
  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(vec_o));
`endif
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        lvl;
    logic [15:0] vec;
    logic [3:0]  ack;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
  logic rx_flag = 0, tx_flag = 0, tmr2_ovf_flag = 0, tmr2_ext_flag = 0;
  logic [5:0] grp_en = 6'h3F;
  logic glob_en = 1'b1;
  logic [5:0] grp_hi = 6'h00;
  logic insn_done = 0, guard_insn = 0, ret_irq = 0;
  logic take_o, take_lvl_o;
  logic [15:0] vec_o;
  logic [3:0] flag_ack_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  exp_t exp_q[$];
  exp_t mon_e;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag),
    .ext1_flag(ext1_flag), .tmr1_flag(tmr1_flag),
    .rx_flag(rx_flag), .tx_flag(tx_flag),
    .tmr2_ovf_flag(tmr2_ovf_flag), .tmr2_ext_flag(tmr2_ext_flag),
    .grp_en(grp_en), .glob_en(glob_en), .grp_hi(grp_hi),
    .insn_done(insn_done), .guard_insn(guard_insn), .ret_irq(ret_irq),
    .take_o(take_o), .take_lvl_o(take_lvl_o), .vec_o(vec_o),
    .flag_ack_o(flag_ack_o)
  );

  // Monitor: compares every acknowledge against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (take_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected take vec=%h lvl=%0d, expected none",
                   cur_tag, vec_o, take_lvl_o);
        end else begin
          mon_e = exp_q.pop_front();
          if (vec_o !== mon_e.vec || take_lvl_o !== mon_e.lvl || flag_ack_o !== mon_e.ack) begin
            errors++;
            $display("FAIL %s got vec=%h lvl=%0d ack=%b expected vec=%h lvl=%0d ack=%b",
                     cur_tag, vec_o, take_lvl_o, flag_ack_o, mon_e.vec, mon_e.lvl, mon_e.ack);
          end
        end
      end else if (flag_ack_o !== 4'b0) begin
        checks++;
        errors++;
        $display("FAIL R10 ack=%b without take, expected 0000", flag_ack_o);
      end
      if (flag_ack_o[0]) ext0_flag = 1'b0;
      if (flag_ack_o[1]) tmr0_flag = 1'b0;
      if (flag_ack_o[2]) ext1_flag = 1'b0;
      if (flag_ack_o[3]) tmr1_flag = 1'b0;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired, got hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic bnd();
    tick(); insn_done = 1'b1;
    tick(); insn_done = 1'b0;
  endtask

  task automatic do_ret();
    tick(); insn_done = 1'b1; ret_irq = 1'b1;
    tick(); insn_done = 1'b0; ret_irq = 1'b0;
  endtask

  task automatic push(input logic lvl, input logic [15:0] vec, input logic [3:0] ack, input string tag);
    exp_t e;
    e.lvl = lvl; e.vec = vec; e.ack = ack;
    cur_tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drained(input string tag);
    cur_tag = tag;
    @(negedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s expected take missing, got %0d queued expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (take_o !== 1'b0 || take_lvl_o !== 1'b0 || vec_o !== 16'h0 || flag_ack_o !== 4'h0) begin
      errors++;
      $display("FAIL R1 got take=%b lvl=%b vec=%h ack=%b expected all zero",
               take_o, take_lvl_o, vec_o, flag_ack_o);
    end

    // R5 R10: single low request on group 0
    tick(); ext0_flag = 1'b1;
    push(1'b0, 16'h0003, 4'b0001, "R5"); bnd(); drained("R5");
    do_ret(); drained("R9");

    // R5: three pending low groups served in polling order
    tick(); ext1_flag = 1'b1; tmr1_flag = 1'b1; rx_flag = 1'b1;
    push(1'b0, 16'h0013, 4'b0100, "R5"); bnd(); drained("R5");
    do_ret(); drained("R9");
    push(1'b0, 16'h001B, 4'b1000, "R5"); bnd(); drained("R5");
    do_ret();
    push(1'b0, 16'h0023, 4'b0000, "R10"); bnd(); drained("R10");
    tick(); rx_flag = 1'b0;
    do_ret(); bnd(); drained("R10");
    // R11: vector holds after the pulse
    checks++;
    if (take_o !== 1'b0 || vec_o !== 16'h0023) begin
      errors++;
      $display("FAIL R11 got take=%b vec=%h expected 0 0023", take_o, vec_o);
    end

    // R2: local mask then global mask
    tick(); grp_en = 6'h3E; ext0_flag = 1'b1;
    bnd(); drained("R2");
    tick(); grp_en = 6'h3F; glob_en = 1'b0;
    bnd(); drained("R2");
    tick(); glob_en = 1'b1;
    push(1'b0, 16'h0003, 4'b0001, "R2"); bnd(); drained("R2");
    do_ret();

    // R7 R8: nesting
    tick(); tmr0_flag = 1'b1;
    push(1'b0, 16'h000B, 4'b0010, "R7"); bnd(); drained("R7");
    tick(); grp_hi = 6'b100100; ext1_flag = 1'b1;
    push(1'b1, 16'h0013, 4'b0100, "R7"); bnd(); drained("R7");
    tick(); ext0_flag = 1'b1;
    bnd(); drained("R7");
    tick(); tmr2_ovf_flag = 1'b1;
    bnd(); drained("R7");
    do_ret();
    push(1'b1, 16'h002B, 4'b0000, "R7"); bnd(); drained("R7");
    tick(); tmr2_ovf_flag = 1'b0;
    do_ret(); bnd(); drained("R8");
    do_ret();
    push(1'b0, 16'h0003, 4'b0001, "R8"); bnd(); drained("R8");
    do_ret();

    // R6: high group served before a lower-numbered low group
    tick(); grp_hi = 6'b001000; ext0_flag = 1'b1; tmr1_flag = 1'b1;
    push(1'b1, 16'h001B, 4'b1000, "R6"); bnd(); drained("R6");
    do_ret();
    push(1'b0, 16'h0003, 4'b0001, "R6"); bnd(); drained("R6");
    do_ret();
    tick(); grp_hi = 6'b000000;

    // R9: guarded instruction boundary, then guard in mid-instruction
    tick(); tmr0_flag = 1'b1;
    tick(); insn_done = 1'b1; guard_insn = 1'b1;
    tick(); insn_done = 1'b0; guard_insn = 1'b0;
    drained("R9");
    push(1'b0, 16'h000B, 4'b0010, "R9"); bnd(); drained("R9");
    do_ret();
    tick(); ext0_flag = 1'b1;
    tick(); guard_insn = 1'b1;
    tick(); guard_insn = 1'b0;
    bnd(); drained("R9");
    push(1'b0, 16'h0003, 4'b0001, "R9"); bnd(); drained("R9");
    do_ret();

    // R3: request rising in the boundary cycle
    tick(); ext1_flag = 1'b1; insn_done = 1'b1;
    tick(); insn_done = 1'b0;
    drained("R3");
    push(1'b0, 16'h0013, 4'b0100, "R3"); bnd(); drained("R3");
    do_ret();

    // R5 R10: timer-2 shared vector via second flag
    tick(); tmr2_ext_flag = 1'b1;
    push(1'b0, 16'h002B, 4'b0000, "R10"); bnd(); drained("R10");
    tick(); tmr2_ext_flag = 1'b0;
    do_ret();

    // R4: no boundary, no entry
    tick(); tmr1_flag = 1'b1;
    repeat (6) tick();
    drained("R4");
    push(1'b0, 16'h001B, 4'b1000, "R4"); bnd(); drained("R4");
    do_ret();

    repeat (3) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule